// File: doc/BRIEF.md
# Offset-Encoded Two-Level Branch Target Buffer

This block predicts where a branch goes. Each entry keeps only a short signed displacement, not a full address, and the predicted target is formed by adding that displacement to the PC that was looked up. Most branches jump a short way, so a narrow field covers nearly all of them and the arrays stay small. A resolved branch whose displacement does not fit the field is rejected and reported on a one-cycle flag.

There are two levels. A tiny fully associative fast level answers one cycle after the lookup. A larger set-associative main level answers two cycles after it, so a branch known only to the main level costs one empty slot on the prediction strobe. The front end presents one fetch PC per cycle and receives a valid strobe, a level indicator and a target. Resolved branches come back on an update port. A flush input empties both levels at once. Sizes are parameters, and the defaults are small.

Top module: `ofs_btb`

## Requirements
- R1: While reset is held and after it is released with no traffic, `pred_vld`, `pred_main` and `upd_unenc` are 0.
- R2: A reported target equals the looked-up PC plus the stored displacement, sign-extended from OFS_W bits, taken modulo 2^PC_W.
- R3: A lookup that hits the fast level raises `pred_vld` in the next cycle with `pred_main`=0 and no second report.
- R4: A lookup that misses the fast level but hits the main level gives `pred_vld`=0 in the next cycle, then `pred_vld`=1 with `pred_main`=1 two cycles after the lookup.
- R5: When the main level reports, the lookup that followed its lookup by one cycle is discarded: neither its fast nor its main result is ever reported. A lookup that follows a fast-level report is not discarded.
- R6: A lookup hits only an entry that is valid and whose stored tag matches. The main-level set index is PC[log2(MAIN_SETS)-1:0] and the tag is the remaining upper bits. A PC never written, or one that shares a set but not a tag, misses.
- R7: If upd_tgt - upd_pc, taken as a PC_W-bit two's-complement value, lies outside [-2^(OFS_W-1), 2^(OFS_W-1)-1], nothing is written to either level, any existing entry for that PC is kept, and `upd_unenc` is 1 for exactly the cycle after the update.
- R8: An encodable update whose PC is absent from the main level is placed in the way named by its set's round-robin pointer. The pointer starts at way 0 and advances on each such placement. An update whose PC is present overwrites the displacement in place and does not move the pointer.
- R9: An encodable update enters the fast level only when its PC is already in the fast level or already in the main level. A new fast entry takes the lowest-index free slot, or, when every slot is valid, the slot least recently written by an update.
- R10: A flush invalidates every entry of both levels in one cycle and discards lookups still in flight, including one presented in the flush cycle. `pred_vld` is 0 in the cycle after a flush.
- R11: An encodable update whose PC is in the fast level replaces that entry's displacement and makes it the most recently written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate both levels and drop in-flight lookups |
| lkp_vld | input | 1 | Lookup request this cycle |
| lkp_pc | input | PC_W | Fetch PC to look up |
| upd_vld | input | 1 | Resolved-branch update this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_tgt | input | PC_W | Actual target of the resolved branch |
| pred_vld | output | 1 | A prediction is reported this cycle |
| pred_main | output | 1 | 1: the main level answered; 0: the fast level answered |
| pred_tgt | output | PC_W | Predicted target; 0 when pred_vld is 0 |
| upd_unenc | output | 1 | The update of the previous cycle had an unencodable displacement |

## Verification
The checker tests the timing contract on every cycle. A fast answer must trace to a lookup one cycle earlier and a main answer to one two cycles earlier. A main answer must follow an empty strobe slot and can never be followed directly by another main answer, and the strobe must be quiet right after a flush. The values of the predicted targets, the displacement-range boundary, round-robin eviction in the main level, recency replacement in the fast level and the survival of old entries after a rejected update appear only in the bench's scenarios. Those scenarios sweep the displacement across and beyond the encodable range at a PC near the wrap point.

// File: rtl/ofs_btb_pkg.sv
package ofs_btb_pkg;
  // which level, if any, drives the prediction this cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_MAIN = 2'd2
  } pred_src_e;
endpackage

// File: rtl/ofs_btb_enc.sv
module ofs_btb_enc #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  tgt,
  output logic [OFS_W-1:0] ofs,
  output logic             fits
);
  // bits that must all equal the sign bit of the short field
  localparam int HI_W = PC_W - OFS_W + 1;

  logic [PC_W-1:0] diff;
  logic [HI_W-1:0] hi;

  always_comb begin
    diff = tgt - pc;
    hi   = diff[PC_W-1:OFS_W-1];
    ofs  = diff[OFS_W-1:0];
    fits = (&hi) | ~(|hi);
  end
endmodule

// File: rtl/ofs_btb_fast.sv
module ofs_btb_fast #(
  parameter int PC_W    = 12,
  parameter int OFS_W   = 8,
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PC_W-1:0]  rd_pc,
  output logic             rd_hit,
  output logic [OFS_W-1:0] rd_ofs,
  input  logic             wr_en,
  input  logic             wr_alloc,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [OFS_W-1:0] wr_ofs
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int AGE_W = IDX_W;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [PC_W-1:0]    pc_q  [ENTRIES];
  logic [PC_W-1:0]    pc_d  [ENTRIES];
  logic [OFS_W-1:0]   ofs_q [ENTRIES];
  logic [OFS_W-1:0]   ofs_d [ENTRIES];
  logic [AGE_W-1:0]   age_q [ENTRIES];
  logic [AGE_W-1:0]   age_d [ENTRIES];

  logic [ENTRIES-1:0] rd_match, wr_match;
  logic               hit_any, free_any, touch;
  logic [IDX_W-1:0]   hit_idx, free_idx, lru_idx, tgt_idx;

  // fully associative compare, one comparator per slot and port
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign rd_match[g] = vld_q[g] && (pc_q[g] == rd_pc);
    assign wr_match[g] = vld_q[g] && (pc_q[g] == wr_pc);
  end

  always_comb begin
    rd_ofs = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_match[i]) rd_ofs = rd_ofs | ofs_q[i];
    end
    rd_hit = |rd_match;
  end

  // slot selection: existing entry, else first free, else oldest
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_match[i] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld_q[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (age_q[i] == AGE_W'(ENTRIES - 1)) lru_idx = IDX_W'(i);
    end
    touch   = wr_en && (hit_any || wr_alloc);
    tgt_idx = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
  end

  // next state: ages stay a permutation of 0..ENTRIES-1
  always_comb begin
    vld_d = vld_q;
    pc_d  = pc_q;
    ofs_d = ofs_q;
    age_d = age_q;
    if (touch) begin
      vld_d[tgt_idx] = 1'b1;
      pc_d[tgt_idx]  = wr_pc;
      ofs_d[tgt_idx] = wr_ofs;
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == tgt_idx)             age_d[j] = '0;
        else if (age_q[j] < age_q[tgt_idx])   age_d[j] = age_q[j] + 1'b1;
      end
    end
    if (flush) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= AGE_W'(i);
    end else begin
      vld_q <= vld_d;
      if (touch) age_q <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (touch) begin
      pc_q  <= pc_d;
      ofs_q <= ofs_d;
    end
  end
endmodule

// File: rtl/ofs_btb_main.sv
module ofs_btb_main #(
  parameter int PC_W  = 12,
  parameter int OFS_W = 8,
  parameter int SETS  = 8,
  parameter int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PC_W-1:0]  rd_pc,
  output logic             rd_hit,
  output logic [OFS_W-1:0] rd_ofs,
  input  logic             wr_en,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [OFS_W-1:0] wr_ofs,
  output logic             wr_hit
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [OFS_W-1:0] ofs_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];
  logic [WAY_W-1:0] rr_d  [SETS];

  logic [IDX_W-1:0] rd_set, wr_set;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [WAY_W-1:0] hit_way, wr_way;
  logic             do_wr;

  assign rd_set = rd_pc[IDX_W-1:0];
  assign rd_tag = rd_pc[PC_W-1:IDX_W];
  assign wr_set = wr_pc[IDX_W-1:0];
  assign wr_tag = wr_pc[PC_W-1:IDX_W];

  always_comb begin
    rd_hit = 1'b0;
    rd_ofs = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag)) begin
        rd_hit = 1'b1;
        rd_ofs = ofs_q[rd_set][w];
      end
    end
  end

  always_comb begin
    wr_hit  = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag)) begin
        wr_hit  = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    wr_way = wr_hit ? hit_way : rr_q[wr_set];
    do_wr  = wr_en;
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (do_wr) begin
      vld_d[wr_set][wr_way] = 1'b1;
      if (!wr_hit) begin
        if (rr_q[wr_set] == WAY_W'(WAYS - 1)) rr_d[wr_set] = '0;
        else                                  rr_d[wr_set] = rr_q[wr_set] + 1'b1;
      end
    end
    if (flush) begin
      for (int s = 0; s < SETS; s++) vld_d[s] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      if (do_wr) rr_q <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      ofs_q[wr_set][wr_way] <= wr_ofs;
    end
  end
endmodule

// File: rtl/ofs_btb.sv
module ofs_btb
  import ofs_btb_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int OFS_W     = 8,
  parameter int MAIN_SETS = 8,
  parameter int MAIN_WAYS = 2,
  parameter int FAST_N    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lkp_vld,
  input  logic [PC_W-1:0] lkp_pc,
  input  logic            upd_vld,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_tgt,
  output logic            pred_vld,
  output logic            pred_main,
  output logic [PC_W-1:0] pred_tgt,
  output logic            upd_unenc
);
  localparam int EXT_W = PC_W - OFS_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // update path
  logic [OFS_W-1:0] enc_ofs;
  logic             enc_fits, wr_en, main_wr_hit;

  ofs_btb_enc #(.PC_W(PC_W), .OFS_W(OFS_W)) enc_i (
    .pc(upd_pc), .tgt(upd_tgt), .ofs(enc_ofs), .fits(enc_fits)
  );

  assign wr_en = upd_vld & enc_fits & ~flush;

  // fast level, read in the lookup cycle
  logic             f_hit;
  logic [OFS_W-1:0] f_ofs;

  ofs_btb_fast #(.PC_W(PC_W), .OFS_W(OFS_W), .ENTRIES(FAST_N)) fast_i (
    .clk(clk), .rst_n(rst_int_n), .flush(flush),
    .rd_pc(lkp_pc), .rd_hit(f_hit), .rd_ofs(f_ofs),
    .wr_en(wr_en), .wr_alloc(main_wr_hit), .wr_pc(upd_pc), .wr_ofs(enc_ofs)
  );

  // stage 1 registers
  logic             s1_vld_q, s1_vld_d, s1_fhit_q;
  logic [PC_W-1:0]  s1_pc_q;
  logic [OFS_W-1:0] s1_fofs_q;

  // main level, read from the stage-1 PC
  logic             m_hit;
  logic [OFS_W-1:0] m_ofs;

  ofs_btb_main #(.PC_W(PC_W), .OFS_W(OFS_W), .SETS(MAIN_SETS), .WAYS(MAIN_WAYS)) main_i (
    .clk(clk), .rst_n(rst_int_n), .flush(flush),
    .rd_pc(s1_pc_q), .rd_hit(m_hit), .rd_ofs(m_ofs),
    .wr_en(wr_en), .wr_pc(upd_pc), .wr_ofs(enc_ofs), .wr_hit(main_wr_hit)
  );

  // stage 2 registers
  logic             s2_vld_q, s2_vld_d, s2_fhit_q, s2_mhit_q;
  logic [PC_W-1:0]  s2_pc_q;
  logic [OFS_W-1:0] s2_mofs_q;
  logic             unenc_q, unenc_d;

  logic      main_fire, fast_fire;
  pred_src_e src;

  always_comb begin
    main_fire = s2_vld_q & ~s2_fhit_q & s2_mhit_q;
    fast_fire = s1_vld_q & s1_fhit_q & ~main_fire;
    s1_vld_d  = lkp_vld & ~flush;
    // a main-level redirect makes the younger lookup wrong-path
    s2_vld_d  = s1_vld_q & ~main_fire & ~flush;
    unenc_d   = upd_vld & ~enc_fits;
    if (main_fire)      src = SRC_MAIN;
    else if (fast_fire) src = SRC_FAST;
    else                src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      unenc_q  <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s2_vld_q <= s2_vld_d;
      unenc_q  <= unenc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lkp_vld) begin
      s1_pc_q   <= lkp_pc;
      s1_fhit_q <= f_hit;
      s1_fofs_q <= f_ofs;
    end
    if (s1_vld_q) begin
      s2_pc_q   <= s1_pc_q;
      s2_fhit_q <= s1_fhit_q;
      s2_mhit_q <= m_hit;
      s2_mofs_q <= m_ofs;
    end
  end

  always_comb begin
    unique case (src)
      SRC_MAIN: pred_tgt = s2_pc_q + {{EXT_W{s2_mofs_q[OFS_W-1]}}, s2_mofs_q};
      SRC_FAST: pred_tgt = s1_pc_q + {{EXT_W{s1_fofs_q[OFS_W-1]}}, s1_fofs_q};
      default:  pred_tgt = '0;
    endcase
    pred_vld  = (src != SRC_NONE);
    pred_main = (src == SRC_MAIN);
  end

  assign upd_unenc = unenc_q;
endmodule

// File: rtl/ofs_btb_chk.sv
module ofs_btb_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic lkp_vld,
  input logic upd_vld,
  input logic pred_vld,
  input logic pred_main,
  input logic upd_unenc
);
  assert_main_has_vld_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_main |-> pred_vld);

  assert_main_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld && pred_main) |-> $past(lkp_vld, 2));

  assert_fast_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_vld && !pred_main) |-> $past(lkp_vld));

  assert_main_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_main |-> !$past(pred_vld));

  assert_wrong_path_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_main |=> !pred_main);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_vld);

  assert_unenc_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_unenc |-> $past(upd_vld));
endmodule

bind ofs_btb ofs_btb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lkp_vld(lkp_vld), .upd_vld(upd_vld),
  .pred_vld(pred_vld), .pred_main(pred_main), .upd_unenc(upd_unenc)
);

// File: tb/ofs_btb_tb_top.sv
module ofs_btb_tb_top;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            flush;
  logic            lkp_vld;
  logic [PC_W-1:0] lkp_pc;
  logic            upd_vld;
  logic [PC_W-1:0] upd_pc;
  logic [PC_W-1:0] upd_tgt;
  logic            pred_vld, pred_main, upd_unenc;
  logic [PC_W-1:0] pred_tgt;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ofs_btb #(.PC_W(PC_W), .OFS_W(8), .MAIN_SETS(8), .MAIN_WAYS(2), .FAST_N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lkp_vld(lkp_vld), .lkp_pc(lkp_pc),
    .upd_vld(upd_vld), .upd_pc(upd_pc), .upd_tgt(upd_tgt),
    .pred_vld(pred_vld), .pred_main(pred_main), .pred_tgt(pred_tgt), .upd_unenc(upd_unenc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic obs(input string req, input bit ev, input bit em, input logic [PC_W-1:0] et);
    check(req, pred_vld, ev);
    if (ev) begin
      check(req, pred_main, em);
      check(req, pred_tgt, et);
    end
  endtask

  // kind: 0 miss, 1 fast answer, 2 main answer
  task automatic lookup(input logic [PC_W-1:0] pc, input int kind,
                        input logic [PC_W-1:0] tgt, input string req);
    lkp_vld = 1'b1;
    lkp_pc  = pc;
    @(negedge clk);
    lkp_vld = 1'b0;
    obs(req, kind == 1, 1'b0, tgt);
    @(negedge clk);
    obs(req, kind == 2, 1'b1, tgt);
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt, input bit bad);
    upd_vld = 1'b1;
    upd_pc  = pc;
    upd_tgt = tgt;
    @(negedge clk);
    upd_vld = 1'b0;
    check("R7 flag", upd_unenc, bad);
    @(negedge clk);
    check("R7 one-cycle", upd_unenc, 1'b0);
  endtask

  // two lookups on consecutive cycles, then four observed cycles
  task automatic pair(input logic [PC_W-1:0] pa, input logic [PC_W-1:0] pb,
                      input bit v0, input bit m0, input logic [PC_W-1:0] t0,
                      input bit v1, input bit m1, input logic [PC_W-1:0] t1,
                      input bit v2, input bit m2, input logic [PC_W-1:0] t2,
                      input string req);
    lkp_vld = 1'b1;
    lkp_pc  = pa;
    @(negedge clk);
    lkp_pc  = pb;
    obs(req, v0, m0, t0);
    @(negedge clk);
    lkp_vld = 1'b0;
    obs(req, v1, m1, t1);
    @(negedge clk);
    obs(req, v2, m2, t2);
    @(negedge clk);
    check(req, pred_vld, 1'b0);
  endtask

  function automatic logic [PC_W-1:0] d1(input int i);
    return PC_W'(i * 36 - 128);
  endfunction

  function automatic logic [PC_W-1:0] d2(input int i);
    return PC_W'(127 - i * 30);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; lkp_vld = 1'b0; lkp_pc = '0;
    upd_vld = 1'b0; upd_pc = '0; upd_tgt = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", pred_vld, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vld", pred_vld, 1'b0);
    check("R1 main", pred_main, 1'b0);
    check("R1 unenc", upd_unenc, 1'b0);
    lookup(12'h100, 0, '0, "R6 empty");

    // first writes: main level only
    for (int i = 0; i < 8; i++) update(12'h100 + PC_W'(i), 12'h100 + PC_W'(i) + d1(i), 1'b0);
    for (int i = 0; i < 8; i++) lookup(12'h100 + PC_W'(i), 2, 12'h100 + PC_W'(i) + d1(i), "R2 R4 main");

    // second writes: in-place main overwrite, fast fill then recency eviction
    for (int i = 0; i < 8; i++) update(12'h100 + PC_W'(i), 12'h100 + PC_W'(i) + d2(i), 1'b0);
    for (int i = 0; i < 4; i++) lookup(12'h100 + PC_W'(i), 2, 12'h100 + PC_W'(i) + d2(i), "R8 R9 evicted");
    for (int i = 4; i < 8; i++) lookup(12'h100 + PC_W'(i), 1, 12'h100 + PC_W'(i) + d2(i), "R3 R9 fast");

    // R11: refresh 0x104, then install 0x100 evicts 0x105
    update(12'h104, 12'h109, 1'b0);
    update(12'h100, 12'h109, 1'b0);
    lookup(12'h104, 1, 12'h109, "R11 refreshed");
    lookup(12'h105, 2, 12'h105 + d2(5), "R11 evicted");
    lookup(12'h100, 1, 12'h109, "R9 installed");
    lookup(12'h106, 1, 12'h106 + d2(6), "R9 kept");

    // R6: same set, other tag
    for (int i = 0; i < 8; i++) lookup(12'h900 + PC_W'(i), 0, '0, "R6 alias");

    // R8: round robin in set 1
    update(12'h201, 12'h204, 1'b0);
    update(12'h301, 12'h305, 1'b0);
    lookup(12'h101, 0, '0, "R8 victim");
    lookup(12'h201, 2, 12'h204, "R8 way1");
    lookup(12'h301, 2, 12'h305, "R8 way0");

    // R7: out-of-range displacements are dropped
    update(12'h150, 12'h1D0, 1'b1);
    lookup(12'h150, 0, '0, "R7 +128");
    update(12'h151, 12'h0D0, 1'b1);
    lookup(12'h151, 0, '0, "R7 -129");
    update(12'h201, 12'h2C9, 1'b1);
    lookup(12'h201, 2, 12'h204, "R7 keep old");

    // R5: wrong-path drop after a main answer, none after a fast one
    pair(12'h201, 12'h301, 0,0,'0, 1,1,12'h204, 0,0,'0, "R5 main-main");
    pair(12'h201, 12'h106, 0,0,'0, 1,1,12'h204, 0,0,'0, "R5 main-fast");
    pair(12'h104, 12'h301, 1,0,12'h109, 0,0,'0, 1,1,12'h305, "R5 fast-main");

    // R10: flush kills in-flight lookups and both levels
    lkp_vld = 1'b1; lkp_pc = 12'h104; flush = 1'b1;
    @(negedge clk);
    lkp_vld = 1'b0; flush = 1'b0;
    check("R10 same-cycle lookup", pred_vld, 1'b0);
    @(negedge clk);
    lookup(12'h201, 0, '0, "R10 pre");
    lkp_vld = 1'b1; lkp_pc = 12'h201;
    @(negedge clk);
    lkp_vld = 1'b0; flush = 1'b1;
    check("R10 stage1", pred_vld, 1'b0);
    @(negedge clk);
    flush = 1'b0;
    check("R10 in flight", pred_vld, 1'b0);
    lookup(12'h104, 0, '0, "R10 fast gone");
    lookup(12'h301, 0, '0, "R10 main gone");
    lookup(12'h100, 0, '0, "R10 both gone");

    // displacement sweep across the encodable range near the wrap point
    begin
      int seen = 0;
      logic [PC_W-1:0] last_t = '0;
      for (int d = -132; d <= 131; d++) begin
        bit bad = (d < -128) || (d > 127);
        logic [PC_W-1:0] t = 12'hFF8 + PC_W'(d);
        update(12'hFF8, t, bad);
        if (!bad) begin
          seen++;
          last_t = t;
        end
        lookup(12'hFF8, (seen == 0) ? 0 : ((seen == 1) ? 2 : 1), last_t, "R2 R7 sweep");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule